// File: doc/BRIEF.md
# Energy-to-Pulse Frequency Output Generator

This block converts a stream of signed energy samples into a train of active-low pulses. The average pulse rate is proportional to the energy that has built up. One sample arrives on a strobe once per sampling period, which is nominally every 1024 clocks. The sample is scaled by a programmable rate code and added to a private signed accumulator. Each time the accumulator's magnitude reaches one energy quantum, one pulse leaves on the pulse pin and one quantum is taken back out of the accumulator towards zero. A large sample therefore produces a burst of back-to-back pulses. Energy that is not yet sent stays pending for later.

A second pin shows the sign of the energy being paid out. It idles high, and it mirrors the pulse pin only for pulses drawn from a negative accumulator. Pulse width follows the rate code: higher rates give shorter pulses. The width is bounded below so that pulses never come faster than one sixteenth of the clock, and bounded above so that slow rates keep a fixed width.

Top module: `epo_pulse_out`

## Requirements
- R1: Reset drives `pulse_n` and `dir_n` high and clears the accumulator, so energy held before reset never yields a pulse after it.
- R2: Both pins stay high while the accumulator magnitude is below one quantum, where one quantum is 2^QLOG; a pulse is a run of low cycles on `pulse_n`.
- R3: On each clock with `sample_stb` high, `energy_in * rate_code` (signed times unsigned) is added to the accumulator. Exactly one pulse is emitted per quantum, and the sub-quantum remainder carries over to later samples.
- R4: Pulse width in clocks is 2^e, where e = REF_LOG2 - (index of the highest set bit of `rate_code`), clamped to the range MIN_LOG2..MAX_LOG2.
- R5: For low rates (a highest set bit at or below REF_LOG2 - MAX_LOG2, or a code of zero), the width stays fixed at 2^MAX_LOG2 clocks.
- R6: `dir_n` stays high for pulses drawn from a positive accumulator. For pulses drawn from a negative accumulator it carries the same waveform as `pulse_n`.
- R7: Pulses within a burst are separated by exactly as many high cycles as the pulse width. A pulse starts on the clock after the accumulator first holds a full quantum.
- R8: Quanta that cannot be sent within one sampling period stay pending and go out in later periods; none is lost.
- R9: The width is taken from `rate_code` when a pulse starts, so a change of `rate_code` during a pulse does not alter that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_stb | input | 1 | One-cycle strobe marking a new energy sample |
| energy_in | input | E_W | Signed energy sample, read when `sample_stb` is high |
| rate_code | input | RATE_W | Unsigned pulse-rate setting; scales energy and selects the pulse width |
| pulse_n | output | 1 | Active-low energy pulse |
| dir_n | output | 1 | Active-low copy of the pulse for negative energy |

## Verification
The bench builds the block with QLOG=22 and keeps the default width parameters (REF_LOG2=23, MIN_LOG2=3, MAX_LOG2=6). With these values, single-digit to four-digit energies at rate codes between 2^14 and 2^20 produce from zero up to about twenty quanta per sample. That range reaches every width from 8 to 64 clocks and the low-rate floor. It also allows a burst long enough to spill over several sampling periods, and exact or fractional remainders whose carry-over decides whether a later sample pulses. A reference model built on plain integers is compared with both pins on every clock.

// File: rtl/epo_pkg.sv
`timescale 1ns/1ps
package epo_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_GAP  = 2'd2
    } epo_state_e;

endpackage

// File: rtl/epo_width_sel.sv
`timescale 1ns/1ps
// Maps a rate code to (pulse width - 1), width = 2^e with e clamped.
module epo_width_sel #(
    parameter int RATE_W   = 24,
    parameter int REF_LOG2 = 23,
    parameter int MIN_LOG2 = 3,
    parameter int MAX_LOG2 = 6,
    localparam int CNT_W   = MAX_LOG2
) (
    input  logic [RATE_W-1:0] rate,
    output logic [CNT_W-1:0]  width_m1
);

    int top_bit;
    int expo;

    always_comb begin
        top_bit = -1;
        for (int i = 0; i < RATE_W; i++) begin
            if (rate[i]) top_bit = i;
        end
        if (top_bit < 0) begin
            expo = MAX_LOG2;
        end else begin
            expo = REF_LOG2 - top_bit;
        end
        if (expo > MAX_LOG2) expo = MAX_LOG2;
        if (expo < MIN_LOG2) expo = MIN_LOG2;
        width_m1 = CNT_W'((1 << expo) - 1);
    end

endmodule

// File: rtl/epo_accum.sv
`timescale 1ns/1ps
// Signed energy accumulator: adds scaled samples, pays out one quantum per pulse.
module epo_accum #(
    parameter int E_W    = 16,
    parameter int RATE_W = 24,
    parameter int QLOG   = 32,
    localparam int PROD_W = E_W + RATE_W + 1,
    localparam int ACC_W  = E_W + RATE_W + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sample_stb,
    input  logic signed [E_W-1:0]    energy,
    input  logic [RATE_W-1:0]        rate,
    input  logic                     take,
    output logic                     has_pos,
    output logic                     has_neg
);

    localparam logic [ACC_W-1:0] QUANT = {{(ACC_W-1){1'b0}}, 1'b1} << QLOG;

    typedef struct packed {
        logic signed [ACC_W-1:0] acc;
    } acc_t;

    acc_t cur_q, nxt_d;

    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  add_v;
    logic signed [ACC_W-1:0]  sub_v;
    logic signed [ACC_W-1:0]  q_pos;
    logic signed [ACC_W-1:0]  q_neg;

    assign q_pos = $signed(QUANT);
    assign q_neg = -q_pos;
    assign prod  = $signed({{(RATE_W+1){energy[E_W-1]}}, energy})
                 * $signed({{E_W{1'b0}}, 1'b0, rate});

    assign has_pos = (cur_q.acc >= q_pos);
    assign has_neg = (cur_q.acc <= q_neg);

    always_comb begin
        nxt_d = cur_q;
        add_v = sample_stb ? {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod} : '0;
        if (take) begin
            sub_v = cur_q.acc[ACC_W-1] ? q_neg : q_pos;
        end else begin
            sub_v = '0;
        end
        nxt_d.acc = cur_q.acc + add_v - sub_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{acc: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

endmodule

// File: rtl/epo_pulse_out.sv
`timescale 1ns/1ps
// Energy-to-pulse output: accumulator, width select and pulse sequencer.
module epo_pulse_out #(
    parameter int E_W      = 16,
    parameter int RATE_W   = 24,
    parameter int QLOG     = 32,
    parameter int REF_LOG2 = 23,
    parameter int MIN_LOG2 = 3,
    parameter int MAX_LOG2 = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sample_stb,
    input  logic signed [E_W-1:0] energy_in,
    input  logic [RATE_W-1:0]     rate_code,
    output logic                  pulse_n,
    output logic                  dir_n
);
    import epo_pkg::*;

    localparam int CNT_W = MAX_LOG2;

    typedef struct packed {
        epo_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] wm1;
        logic             neg;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic             has_pos;
    logic             has_neg;
    logic             ready;
    logic             start;
    logic [CNT_W-1:0] wsel_m1;

    epo_accum #(
        .E_W    (E_W),
        .RATE_W (RATE_W),
        .QLOG   (QLOG)
    ) u_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_stb (sample_stb),
        .energy     (energy_in),
        .rate       (rate_code),
        .take       (start),
        .has_pos    (has_pos),
        .has_neg    (has_neg)
    );

    epo_width_sel #(
        .RATE_W   (RATE_W),
        .REF_LOG2 (REF_LOG2),
        .MIN_LOG2 (MIN_LOG2),
        .MAX_LOG2 (MAX_LOG2)
    ) u_width (
        .rate     (rate_code),
        .width_m1 (wsel_m1)
    );

    always_comb begin
        ctl_d = ctl_q;
        ready = (ctl_q.st == ST_IDLE) ||
                ((ctl_q.st == ST_GAP) && (ctl_q.cnt == '0));
        start = ready && (has_pos || has_neg);
        if (start) begin
            ctl_d.st  = ST_LOW;
            ctl_d.cnt = wsel_m1;
            ctl_d.wm1 = wsel_m1;
            ctl_d.neg = has_neg;
        end else begin
            case (ctl_q.st)
                ST_LOW: begin
                    if (ctl_q.cnt == '0) begin
                        ctl_d.st  = ST_GAP;
                        ctl_d.cnt = ctl_q.wm1;
                    end else begin
                        ctl_d.cnt = ctl_q.cnt - 1'b1;
                    end
                end
                ST_GAP: begin
                    if (ctl_q.cnt == '0) begin
                        ctl_d.st = ST_IDLE;
                    end else begin
                        ctl_d.cnt = ctl_q.cnt - 1'b1;
                    end
                end
                default: ctl_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, cnt: '0, wm1: '0, neg: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign pulse_n = (ctl_q.st != ST_LOW);
    assign dir_n   = !((ctl_q.st == ST_LOW) && ctl_q.neg);

endmodule

// File: rtl/epo_pulse_chk.sv
`timescale 1ns/1ps
// Protocol checker for the pulse pins, bound to the top module.
module epo_pulse_chk #(
    parameter int MIN_LOG2 = 3,
    parameter int MAX_LOG2 = 6
) (
    input logic clk,
    input logic rst_n,
    input logic pulse_n,
    input logic dir_n
);

    localparam logic [15:0] MIN_W = 16'(1 << MIN_LOG2);
    localparam logic [15:0] MAX_W = 16'(1 << MAX_LOG2);

    logic [15:0] low_run;
    logic [15:0] high_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run  <= '0;
            high_run <= '1;
        end else begin
            if (!pulse_n) begin
                low_run  <= (low_run == '1) ? low_run : low_run + 1'b1;
                high_run <= '0;
            end else begin
                low_run  <= '0;
                high_run <= (high_run == '1) ? high_run : high_run + 1'b1;
            end
        end
    end

    // R1: pins high while reset is held
    p_reset_high_r1: assert property (@(posedge clk)
        !rst_n |-> (pulse_n && dir_n));

    // R6: direction pin never low outside a pulse
    p_dir_in_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_n |-> !pulse_n);

    // R6: direction fixed for the whole pulse
    p_dir_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_n && $past(!pulse_n)) |-> (dir_n == $past(dir_n)));

    // R4: finished pulse width within the clamped range
    p_width_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_n) |-> ((low_run >= MIN_W) && (low_run <= MAX_W)));

    // R5: no pulse ever longer than the floor width
    p_width_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        low_run <= MAX_W);

    // R7: high time before each pulse at least the minimum width
    p_gap_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulse_n) |-> (high_run >= MIN_W));

endmodule

bind epo_pulse_out epo_pulse_chk #(
    .MIN_LOG2 (MIN_LOG2),
    .MAX_LOG2 (MAX_LOG2)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pulse_n (pulse_n),
    .dir_n   (dir_n)
);

// File: tb/epo_pulse_out_tb_top.sv
`timescale 1ns/1ps
module epo_pulse_out_tb_top;

    localparam int E_W = 16;
    localparam int RATE_W = 24;
    localparam int QLOG = 22;
    localparam int REF_LOG2 = 23;
    localparam int MIN_LOG2 = 3;
    localparam int MAX_LOG2 = 6;
    localparam longint QUANT = longint'(1) << QLOG;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample_stb = 1'b0;
    logic signed [E_W-1:0] energy_in = '0;
    logic [RATE_W-1:0] rate_code = '0;
    logic pulse_n;
    logic dir_n;

    always #2 clk = ~clk;

    epo_pulse_out #(
        .E_W(E_W), .RATE_W(RATE_W), .QLOG(QLOG),
        .REF_LOG2(REF_LOG2), .MIN_LOG2(MIN_LOG2), .MAX_LOG2(MAX_LOG2)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb),
        .energy_in(energy_in), .rate_code(rate_code),
        .pulse_n(pulse_n), .dir_n(dir_n)
    );

    int nchecks = 0;
    int nfail = 0;
    string cur_req = "R1";

    // reference model state
    longint m_acc;
    int m_mode;   // 0 idle, 1 low, 2 gap
    int m_cnt;
    int m_w;
    bit m_neg;

    // observation
    int mism = 0;
    int pulses = 0;
    int negp = 0;
    int low_run = 0;
    int high_run = 100000;
    bit prev_p = 1'b1;
    int widths[$];
    int gaps[$];

    function automatic int exp_width(input longint r);
        int tb;
        int e;
        tb = -1;
        for (int i = 0; i < RATE_W; i++) if (r[i]) tb = i;
        e = (tb < 0) ? MAX_LOG2 : REF_LOG2 - tb;
        if (e > MAX_LOG2) e = MAX_LOG2;
        if (e < MIN_LOG2) e = MIN_LOG2;
        return 1 << e;
    endfunction

    always @(posedge clk) begin
        longint add;
        bit rdy;
        if (!rst_n) begin
            m_acc = 0; m_mode = 0; m_cnt = 0; m_w = 1; m_neg = 0;
        end else begin
            add = sample_stb ? longint'(energy_in) * longint'(rate_code) : 0;
            rdy = (m_mode == 0) || (m_mode == 2 && m_cnt == 0);
            if (rdy && (m_acc >= QUANT || m_acc <= -QUANT)) begin
                m_neg = (m_acc < 0);
                m_acc = m_acc + add + (m_neg ? QUANT : -QUANT);
                m_w = exp_width(longint'(rate_code));
                m_mode = 1;
                m_cnt = m_w - 1;
            end else begin
                m_acc = m_acc + add;
                if (m_mode == 1) begin
                    if (m_cnt == 0) begin m_mode = 2; m_cnt = m_w - 1; end
                    else m_cnt = m_cnt - 1;
                end else if (m_mode == 2) begin
                    if (m_cnt == 0) m_mode = 0;
                    else m_cnt = m_cnt - 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (pulse_n !== !(m_mode == 1) || dir_n !== !(m_mode == 1 && m_neg))
                mism++;
            if (prev_p && !pulse_n) begin
                pulses++;
                if (!dir_n) negp++;
                gaps.push_back(high_run);
            end
            if (!prev_p && pulse_n) widths.push_back(low_run);
            if (pulse_n) begin high_run++; low_run = 0; end
            else begin low_run++; high_run = 0; end
            prev_p = pulse_n;
        end else begin
            prev_p = 1'b1; low_run = 0; high_run = 100000;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        nchecks++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic begin_scn(input string req);
        cur_req = req;
        mism = 0; pulses = 0; negp = 0;
        widths.delete(); gaps.delete();
    endtask

    task automatic end_scn();
        check(mism == 0, cur_req, "cycle mismatches vs model", mism, 0);
    endtask

    task automatic sample(input int e, input int r);
        @(negedge clk);
        energy_in = 16'(e); rate_code = 24'(r); sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0; energy_in = '0;
        repeat (1022) @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        nfail++;
        $display("FAIL %s watchdog actual=%0d expected=%0d", cur_req, 1, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        #1;
        check(pulse_n === 1'b1, "R1", "pulse_n in reset", pulse_n, 1);
        check(dir_n === 1'b1, "R1", "dir_n in reset", dir_n, 1);
        @(negedge clk); rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R7: burst of 2 at width 8, positive
        begin_scn("R7");
        sample(8, 1 << 20); sample(0, 1 << 20);
        check(pulses == 2, "R3", "pulse count 8*2^20", pulses, 2);
        check(widths.size() > 0 && widths[0] == 8, "R4", "width at 2^20",
              widths.size() > 0 ? widths[0] : -1, 8);
        check(gaps.size() > 1 && gaps[1] == 8, "R7", "burst gap",
              gaps.size() > 1 ? gaps[1] : -1, 8);
        check(negp == 0, "R6", "dir low on positive", negp, 0);
        end_scn();

        // R6: negative burst
        begin_scn("R6");
        sample(-12, 1 << 20); sample(0, 1 << 20);
        check(pulses == 3, "R6", "negative pulse count", pulses, 3);
        check(negp == 3, "R6", "dir follows on negative", negp, 3);
        end_scn();

        // R4: widths 64 and 32
        begin_scn("R4");
        sample(64, 1 << 17); sample(0, 1 << 17);
        check(pulses == 2 && widths.size() > 0 && widths[0] == 64, "R4", "width at 2^17",
              widths.size() > 0 ? widths[0] : -1, 64);
        end_scn();
        begin_scn("R4");
        sample(32, 1 << 18); sample(0, 1 << 18);
        check(pulses == 2 && widths.size() > 0 && widths[0] == 32, "R4", "width at 2^18",
              widths.size() > 0 ? widths[0] : -1, 32);
        end_scn();

        // R5: floor at low rate; residue carried (R3); idle (R2)
        begin_scn("R5");
        sample(1000, 1 << 14);
        check(pulses == 3, "R3", "pulse count 1000*2^14", pulses, 3);
        check(widths.size() > 0 && widths[0] == 64, "R5", "floor width at 2^14",
              widths.size() > 0 ? widths[0] : -1, 64);
        end_scn();
        begin_scn("R3");
        sample(100, 1 << 14);
        check(pulses == 1, "R3", "remainder carried", pulses, 1);
        end_scn();
        begin_scn("R2");
        sample(0, 1 << 14);
        check(pulses == 0, "R2", "idle below quantum", pulses, 0);
        end_scn();

        // R8: burst longer than a sampling period
        begin_scn("R8");
        sample(640, 1 << 17);
        check(pulses == 8, "R8", "pulses in first period", pulses, 8);
        sample(0, 1 << 17); sample(0, 1 << 17);
        check(pulses == 20, "R8", "pending pulses delivered", pulses, 20);
        end_scn();

        // R9: rate change during a pulse
        begin_scn("R9");
        @(negedge clk);
        energy_in = 16'(64); rate_code = 24'(1 << 17); sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0; energy_in = '0;
        repeat (10) @(negedge clk);
        rate_code = 24'(1 << 20);
        repeat (1012) @(negedge clk);
        sample(0, 1 << 20);
        check(widths.size() > 0 && widths[0] == 64, "R9", "width latched",
              widths.size() > 0 ? widths[0] : -1, 64);
        check(widths.size() > 1 && widths[1] == 8, "R9", "next pulse new width",
              widths.size() > 1 ? widths[1] : -1, 8);
        end_scn();

        // R1: reset clears accumulator
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check(pulse_n === 1'b1 && dir_n === 1'b1, "R1", "pins high on reset",
              {pulse_n, dir_n}, 3);
        @(negedge clk); rst_n = 1'b1;
        begin_scn("R1");
        sample(205, 1 << 14); sample(0, 1 << 14);
        check(pulses == 0, "R1", "no pulse from pre-reset energy", pulses, 0);
        sample(205, 1 << 14); sample(0, 1 << 14);
        check(pulses == 1, "R1", "accumulation after reset", pulses, 1);
        end_scn();

        $display("  TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    end

endmodule